// File: doc/BRIEF.md
# Pin routing matrix

The pin routing matrix is a configurable crossbar. It sits between a group of on-chip peripherals (serial port data, bit clocks, frame syncs, timer outputs and similar) and a bank of 20 bidirectional pads. Each pad is modelled as three wires: an output value, an output enable and an input value. For every pad, software picks one signal to drive the pad's output value. It also picks, as a separate choice, the signal that drives that pad's output enable. Any internal peripheral output can go to any pad, and one source may feed several pads at once.

In the other direction, each peripheral input has its own select field. That field picks one of the 20 pad inputs or one of the internal peripheral outputs, so two peripherals can be chained without a pad in between. Every select field also offers constant 0 and constant 1. A pull-up enable register holds one bit per pad. All its bits are set by reset and each can be cleared on its own.

The configuration registers are written through a simple write port: a strobe, an address and data. The routed outputs are registered, so a change of selection never shows up as a combinational glitch on a pad or on a peripheral input. After reset every output enable selects constant 0, so all pads start tri-stated.

Top module: `srm_pin_router`

## Requirements
- R1: After reset `pad_out`, `pad_oe` and `periph_in` are all 0 and `pad_pullup_en` is all ones. Pads are numbered 1 to 20, and pad n uses bit n-1 of each pad vector.
- R2: The data select of pad n sits at address n-1. Code 0 drives constant 0, code 1 drives constant 1, and code 2+k drives `periph_out[k]`. The pad's output register takes the selected value at every clock edge, so a change on a source reaches `pad_out` one edge later.
- R3: The output-enable select of pad n sits at address 19+n. It uses the same code set as R2 and feeds `pad_oe`. It is independent of that pad's data select.
- R4: The select of peripheral input j sits at address 40+j. Code 0 gives constant 0 and code 1 gives constant 1. Codes 2 to 21 give `pad_in` of pads 1 to 20 (bit code-2). Codes 22 to 37 give `periph_out[code-22]`. The result is registered into `periph_in[j]`.
- R5: A write presented at clock edge t updates the configuration register at edge t. The routed outputs show the new selection from edge t+1 onward, and still show the old one between t and t+1.
- R6: The pull-up register sits at address 52. Bit n-1 set enables the pull-up of pad n. A write replaces all 20 bits, and `pad_pullup_en` shows the new value right after the write edge.
- R7: Select codes above the last defined code (pad codes 18 to 31, peripheral input codes 38 to 63) give constant 0.
- R8: Writes to unmapped addresses (53 to 63) change nothing. A cycle with `cfg_we` low changes nothing, whatever `cfg_addr` and `cfg_wdata` carry.
- R9: One internal source selected by several pads drives all of them at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration register address |
| cfg_wdata | input | 20 | Write data (selects use the low bits) |
| periph_out | input | 16 | Outputs of the internal peripherals |
| pad_in | input | 20 | Values sensed at the pads |
| periph_in | output | 12 | Routed, registered inputs to the peripherals |
| pad_out | output | 20 | Registered pad output values |
| pad_oe | output | 20 | Registered pad output enables |
| pad_pullup_en | output | 20 | Pull-up enable per pad |

## Verification
The assertions assume that reset is asserted before the first clock edge. They also assume that the write strobe, address, data and the source vectors hold known values at each rising edge. The bench keeps within these limits: it holds reset over the first edges and changes every input only on falling edges. It also applies out-of-range select codes and unmapped addresses on purpose, so that the properties for constant-zero fallback and for ignored writes are actually exercised and not only reached by chance.

// File: rtl/srm_pkg.sv
package srm_pkg;

    // Select codes shared by every routing field
    localparam int SEL_CONST0    = 0;
    localparam int SEL_CONST1    = 1;
    localparam int SEL_FIRST_SIG = 2;

    // Address regions of the configuration space
    typedef enum logic [2:0] {
        REG_PAD_DATA,
        REG_PAD_OE,
        REG_SINK,
        REG_PULLUP,
        REG_NONE
    } region_e;

endpackage

// File: rtl/srm_cfg_regs.sv
module srm_cfg_regs
    import srm_pkg::*;
#(
    parameter int NUM_PADS = 20,
    parameter int NUM_SRC  = 16,
    parameter int NUM_SINK = 12,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 20,
    parameter int PSEL_W   = 5,
    parameter int SSEL_W   = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [ADDR_W-1:0]                 cfg_addr,
    input  logic [DATA_W-1:0]                 cfg_wdata,
    output logic [NUM_PADS-1:0][PSEL_W-1:0]   pad_dsel,
    output logic [NUM_PADS-1:0][PSEL_W-1:0]   pad_osel,
    output logic [NUM_SINK-1:0][SSEL_W-1:0]   sink_sel,
    output logic [NUM_PADS-1:0]               pullup_en
);

    localparam int OE_BASE     = NUM_PADS;
    localparam int SINK_BASE   = 2 * NUM_PADS;
    localparam int PULLUP_ADDR = SINK_BASE + NUM_SINK;

    region_e           region;
    logic [ADDR_W-1:0] offset;

    // Address decode: split the address into a region and an index inside it
    always_comb begin
        region = REG_NONE;
        offset = '0;
        if (int'(cfg_addr) < OE_BASE) begin
            region = REG_PAD_DATA;
            offset = cfg_addr;
        end else if (int'(cfg_addr) < SINK_BASE) begin
            region = REG_PAD_OE;
            offset = cfg_addr - ADDR_W'(OE_BASE);
        end else if (int'(cfg_addr) < PULLUP_ADDR) begin
            region = REG_SINK;
            offset = cfg_addr - ADDR_W'(SINK_BASE);
        end else if (int'(cfg_addr) == PULLUP_ADDR) begin
            region = REG_PULLUP;
        end
    end

    logic wr_dat, wr_oe, wr_sink, wr_pull;
    assign wr_dat  = cfg_we && (region == REG_PAD_DATA);
    assign wr_oe   = cfg_we && (region == REG_PAD_OE);
    assign wr_sink = cfg_we && (region == REG_SINK);
    assign wr_pull = cfg_we && (region == REG_PULLUP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pad_dsel <= '0;
            pad_osel <= '0;
        end else begin
            for (int p = 0; p < NUM_PADS; p++) begin
                if (wr_dat && offset == ADDR_W'(p))
                    pad_dsel[p] <= cfg_wdata[PSEL_W-1:0];
                if (wr_oe && offset == ADDR_W'(p))
                    pad_osel[p] <= cfg_wdata[PSEL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sink_sel <= '0;
        end else begin
            for (int s = 0; s < NUM_SINK; s++) begin
                if (wr_sink && offset == ADDR_W'(s))
                    sink_sel[s] <= cfg_wdata[SSEL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pullup_en <= '1;
        else if (wr_pull)
            pullup_en <= cfg_wdata[NUM_PADS-1:0];
    end

    // R6: a pull-up write lands on the next edge
    a_r6_pullup_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_W'(PULLUP_ADDR))
        |=> pullup_en == $past(cfg_wdata[NUM_PADS-1:0]));

    // R8: idle cycles leave every configuration field untouched
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(pullup_en) && $stable(pad_dsel)
                     && $stable(pad_osel) && $stable(sink_sel)));

    // R8: unmapped addresses change nothing
    a_r8_unmapped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cfg_addr) > PULLUP_ADDR) |=> ($stable(pullup_en) && $stable(pad_dsel)
                     && $stable(pad_osel) && $stable(sink_sel)));

endmodule

// File: rtl/srm_pad_mux.sv
module srm_pad_mux
    import srm_pkg::*;
#(
    parameter int NUM_PADS = 20,
    parameter int NUM_SRC  = 16,
    parameter int PSEL_W   = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_PADS-1:0][PSEL_W-1:0] pad_dsel,
    input  logic [NUM_PADS-1:0][PSEL_W-1:0] pad_osel,
    input  logic [NUM_SRC-1:0]              periph_out,
    output logic [NUM_PADS-1:0]             pad_out,
    output logic [NUM_PADS-1:0]             pad_oe
);

    localparam int LAST_CODE = SEL_FIRST_SIG + NUM_SRC - 1;

    // Pick one bit by select code: constants first, then sources; undefined codes give 0
    function automatic logic pick(input logic [PSEL_W-1:0] sel,
                                  input logic [NUM_SRC-1:0] src);
        logic r;
        r = 1'b0;
        if (sel == PSEL_W'(SEL_CONST1))
            r = 1'b1;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (sel == PSEL_W'(SEL_FIRST_SIG + k))
                r = src[k];
        end
        return r;
    endfunction

    logic [NUM_PADS-1:0] out_nxt, oe_nxt;

    for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
        assign out_nxt[g] = pick(pad_dsel[g], periph_out);
        assign oe_nxt[g]  = pick(pad_osel[g], periph_out);

        // R3: an enable select of constant 0 leaves the pad tri-stated
        a_r3_oe_low_tristate: assert property (@(posedge clk) disable iff (!rst_n)
            pad_osel[g] == PSEL_W'(SEL_CONST0) |=> !pad_oe[g]);

        // R2: constant 1 drives the pad high
        a_r2_const_one_high: assert property (@(posedge clk) disable iff (!rst_n)
            pad_dsel[g] == PSEL_W'(SEL_CONST1) |=> pad_out[g]);

        // R2: first source code follows periph_out[0] one edge later
        a_r2_first_source: assert property (@(posedge clk) disable iff (!rst_n)
            pad_dsel[g] == PSEL_W'(SEL_FIRST_SIG) |=> pad_out[g] == $past(periph_out[0]));

        // R7: codes past the last source give constant 0
        a_r7_pad_range_low: assert property (@(posedge clk) disable iff (!rst_n)
            pad_dsel[g] > PSEL_W'(LAST_CODE) |=> !pad_out[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pad_out <= '0;
            pad_oe  <= '0;
        end else begin
            pad_out <= out_nxt;
            pad_oe  <= oe_nxt;
        end
    end

endmodule

// File: rtl/srm_sink_mux.sv
module srm_sink_mux
    import srm_pkg::*;
#(
    parameter int NUM_PADS = 20,
    parameter int NUM_SRC  = 16,
    parameter int NUM_SINK = 12,
    parameter int SSEL_W   = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SINK-1:0][SSEL_W-1:0] sink_sel,
    input  logic [NUM_PADS-1:0]             pad_in,
    input  logic [NUM_SRC-1:0]              periph_out,
    output logic [NUM_SINK-1:0]             periph_in
);

    localparam int NCAND     = NUM_PADS + NUM_SRC;
    localparam int LAST_CODE = SEL_FIRST_SIG + NCAND - 1;

    // Candidates: pads first, internal outputs after them
    logic [NCAND-1:0] cand;
    assign cand = {periph_out, pad_in};

    function automatic logic pick(input logic [SSEL_W-1:0] sel,
                                  input logic [NCAND-1:0] c);
        logic r;
        r = 1'b0;
        if (sel == SSEL_W'(SEL_CONST1))
            r = 1'b1;
        for (int k = 0; k < NCAND; k++) begin
            if (sel == SSEL_W'(SEL_FIRST_SIG + k))
                r = c[k];
        end
        return r;
    endfunction

    logic [NUM_SINK-1:0] in_nxt;

    for (genvar g = 0; g < NUM_SINK; g++) begin : g_sink
        assign in_nxt[g] = pick(sink_sel[g], cand);

        // R4: first pad code follows pad 1 one edge later
        a_r4_pad_one_routed: assert property (@(posedge clk) disable iff (!rst_n)
            sink_sel[g] == SSEL_W'(SEL_FIRST_SIG) |=> periph_in[g] == $past(pad_in[0]));

        // R4: first internal code follows periph_out[0] one edge later
        a_r4_internal_routed: assert property (@(posedge clk) disable iff (!rst_n)
            sink_sel[g] == SSEL_W'(SEL_FIRST_SIG + NUM_PADS)
            |=> periph_in[g] == $past(periph_out[0]));

        // R7: undefined codes give constant 0
        a_r7_sink_range_low: assert property (@(posedge clk) disable iff (!rst_n)
            sink_sel[g] > SSEL_W'(LAST_CODE) |=> !periph_in[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            periph_in <= '0;
        else
            periph_in <= in_nxt;
    end

endmodule

// File: rtl/srm_pin_router.sv
module srm_pin_router
    import srm_pkg::*;
#(
    parameter int NUM_PADS = 20,
    parameter int NUM_SRC  = 16,
    parameter int NUM_SINK = 12,
    localparam int PSEL_W  = $clog2(SEL_FIRST_SIG + NUM_SRC),
    localparam int SSEL_W  = $clog2(SEL_FIRST_SIG + NUM_PADS + NUM_SRC),
    localparam int ADDR_W  = $clog2(2 * NUM_PADS + NUM_SINK + 1),
    localparam int DATA_W  = (NUM_PADS > SSEL_W) ? NUM_PADS : SSEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic [NUM_SRC-1:0]  periph_out,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_SINK-1:0] periph_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic [NUM_PADS-1:0] pad_pullup_en
);

    logic [NUM_PADS-1:0][PSEL_W-1:0] pad_dsel;
    logic [NUM_PADS-1:0][PSEL_W-1:0] pad_osel;
    logic [NUM_SINK-1:0][SSEL_W-1:0] sink_sel;

    srm_cfg_regs #(
        .NUM_PADS (NUM_PADS),
        .NUM_SRC  (NUM_SRC),
        .NUM_SINK (NUM_SINK),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .PSEL_W   (PSEL_W),
        .SSEL_W   (SSEL_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .pad_dsel  (pad_dsel),
        .pad_osel  (pad_osel),
        .sink_sel  (sink_sel),
        .pullup_en (pad_pullup_en)
    );

    srm_pad_mux #(
        .NUM_PADS (NUM_PADS),
        .NUM_SRC  (NUM_SRC),
        .PSEL_W   (PSEL_W)
    ) u_pad (
        .clk        (clk),
        .rst_n      (rst_n),
        .pad_dsel   (pad_dsel),
        .pad_osel   (pad_osel),
        .periph_out (periph_out),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    srm_sink_mux #(
        .NUM_PADS (NUM_PADS),
        .NUM_SRC  (NUM_SRC),
        .NUM_SINK (NUM_SINK),
        .SSEL_W   (SSEL_W)
    ) u_sink (
        .clk        (clk),
        .rst_n      (rst_n),
        .sink_sel   (sink_sel),
        .pad_in     (pad_in),
        .periph_out (periph_out),
        .periph_in  (periph_in)
    );

    // R1: reset leaves pads undriven and pull-ups on
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && pad_pullup_en == '1));

endmodule

// File: tb/srm_pin_router_test.sv
module srm_pin_router_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [19:0] cfg_wdata = '0;
    logic [15:0] periph_out = '0;
    logic [19:0] pad_in = '0;
    logic [11:0] periph_in;
    logic [19:0] pad_out;
    logic [19:0] pad_oe;
    logic [19:0] pad_pullup_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    srm_pin_router uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_addr      (cfg_addr),
        .cfg_wdata     (cfg_wdata),
        .periph_out    (periph_out),
        .pad_in        (pad_in),
        .periph_in     (periph_in),
        .pad_out       (pad_out),
        .pad_oe        (pad_oe),
        .pad_pullup_en (pad_pullup_en)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Called at a falling edge; returns one falling edge later (config updated)
    task automatic cfg_write(input int a, input int d);
        cfg_we    = 1'b1;
        cfg_addr  = 6'(a);
        cfg_wdata = 20'(d);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Write and wait until the registered outputs reflect it
    task automatic cfg_apply(input int a, input int d);
        cfg_write(a, d);
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 pad_out", 32'(pad_out), 32'h0);
        check("R1 pad_oe", 32'(pad_oe), 32'h0);
        check("R1 periph_in", 32'(periph_in), 32'h0);
        check("R1 pullup", 32'(pad_pullup_en), 32'hFFFFF);
    endtask

    task automatic t_pad_data;
        cfg_apply(0, 1);                 // pad 1 -> constant 1
        check("R2 pad1 const1", 32'(pad_out[0]), 32'h1);
        cfg_apply(2, 2 + 5);             // pad 3 -> periph_out[5]
        check("R2 pad3 src low", 32'(pad_out[2]), 32'h0);
        periph_out[5] = 1'b1;
        @(negedge clk);
        check("R2 pad3 src high", 32'(pad_out[2]), 32'h1);
        periph_out[5] = 1'b0;
        @(negedge clk);
        check("R2 pad3 src back low", 32'(pad_out[2]), 32'h0);
        cfg_apply(0, 0);                 // pad 1 back to constant 0
        check("R2 pad1 const0", 32'(pad_out[0]), 32'h0);
    endtask

    task automatic t_pad_oe;
        cfg_apply(20 + 2, 1);            // pad 3 enable constant 1
        check("R3 pad3 oe", 32'(pad_oe[2]), 32'h1);
        check("R3 pad3 data untouched", 32'(pad_out[2]), 32'h0);
        cfg_apply(20 + 3, 2 + 7);        // pad 4 enable from periph_out[7]
        periph_out[7] = 1'b1;
        @(negedge clk);
        check("R3 pad4 oe from source", 32'(pad_oe[3]), 32'h1);
        check("R3 pad4 data stays 0", 32'(pad_out[3]), 32'h0);
        periph_out[7] = 1'b0;
        @(negedge clk);
        check("R3 pad4 oe follows source", 32'(pad_oe[3]), 32'h0);
    endtask

    task automatic t_sink;
        cfg_apply(40 + 0, 2 + 9);        // input 0 <- pad 10
        pad_in[9] = 1'b1;
        @(negedge clk);
        check("R4 input0 from pad10", 32'(periph_in[0]), 32'h1);
        pad_in[9] = 1'b0;
        @(negedge clk);
        check("R4 input0 pad10 low", 32'(periph_in[0]), 32'h0);
        cfg_apply(40 + 1, 22 + 3);       // input 1 <- periph_out[3]
        periph_out[3] = 1'b1;
        @(negedge clk);
        check("R4 input1 from internal", 32'(periph_in[1]), 32'h1);
        periph_out[3] = 1'b0;
        cfg_apply(40 + 2, 1);            // input 2 constant 1
        check("R4 input2 const1", 32'(periph_in[2]), 32'h1);
        cfg_apply(40 + 11, 2 + 19);      // last input <- pad 20
        pad_in[19] = 1'b1;
        @(negedge clk);
        check("R4 input11 from pad20", 32'(periph_in[11]), 32'h1);
        pad_in[19] = 1'b0;
    endtask

    task automatic t_latency;
        cfg_write(4, 1);                 // pad 5 constant 1
        check("R5 old value before second edge", 32'(pad_out[4]), 32'h0);
        @(negedge clk);
        check("R5 new value after second edge", 32'(pad_out[4]), 32'h1);
    endtask

    task automatic t_pullup;
        cfg_write(52, 20'h0F0F0);
        check("R6 pullup written", 32'(pad_pullup_en), 32'h0F0F0);
        cfg_write(52, 20'hFFFFE);
        check("R6 pad1 pullup off", 32'(pad_pullup_en), 32'hFFFFE);
    endtask

    task automatic t_range;
        periph_out = 16'hFFFF;
        cfg_apply(5, 1);
        check("R7 pad6 preset high", 32'(pad_out[5]), 32'h1);
        cfg_apply(5, 31);
        check("R7 pad6 code 31 low", 32'(pad_out[5]), 32'h0);
        cfg_apply(5, 18);
        check("R7 pad6 code 18 low", 32'(pad_out[5]), 32'h0);
        cfg_apply(40 + 3, 1);
        cfg_apply(40 + 3, 63);
        check("R7 input3 code 63 low", 32'(periph_in[3]), 32'h0);
        cfg_apply(40 + 3, 38);
        check("R7 input3 code 38 low", 32'(periph_in[3]), 32'h0);
        periph_out = '0;
        @(negedge clk);
    endtask

    task automatic t_ignore;
        logic [19:0] po, oe, pu;
        logic [11:0] pi;
        po = pad_out; oe = pad_oe; pu = pad_pullup_en; pi = periph_in;
        cfg_apply(60, 20'hFFFFF);
        cfg_apply(53, 20'h00001);
        check("R8 unmapped pad_out", 32'(pad_out), 32'(po));
        check("R8 unmapped pad_oe", 32'(pad_oe), 32'(oe));
        check("R8 unmapped pullup", 32'(pad_pullup_en), 32'(pu));
        check("R8 unmapped periph_in", 32'(periph_in), 32'(pi));
        cfg_addr = 6'd52; cfg_wdata = 20'h0; cfg_we = 1'b0;
        @(negedge clk);
        cfg_addr = 6'd0;  cfg_wdata = 20'h1;
        @(negedge clk);
        @(negedge clk);
        check("R8 no strobe pullup", 32'(pad_pullup_en), 32'(pu));
        check("R8 no strobe pad_out", 32'(pad_out), 32'(po));
    endtask

    task automatic t_broadcast;
        cfg_write(6, 2 + 2);
        cfg_write(7, 2 + 2);
        cfg_apply(8, 2 + 2);
        periph_out[2] = 1'b1;
        @(negedge clk);
        check("R9 broadcast high", 32'(pad_out[8:6]), 32'h7);
        periph_out[2] = 1'b0;
        @(negedge clk);
        check("R9 broadcast low", 32'(pad_out[8:6]), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pad_data();
        t_pad_oe();
        t_sink();
        t_latency();
        t_pullup();
        t_range();
        t_ignore();
        t_broadcast();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule